// File: doc/BRIEF.md
# Channel Command Decoder and Executor

This block accepts one channel command at a time: an 8-bit command code, a byte count and a flag that says whether the device behind it is open. It reduces the code to a base operation by running an ordered chain of mask-and-compare tests. It then either finishes the command itself, or hands a read or write to an external data path and waits for that path to finish. Every command ends with a unit-status byte, a residual byte count and a one-cycle completion pulse. A sense byte is kept for later sense commands.

The block holds a single mode flag, called extended mode. Two set-mode commands change it. It also changes how the decoder treats write-class codes, because only in extended mode is a write-end-of-file code seen as its own operation. Results stay on the outputs until the next command completes.

Top module: `chan_cmd_exec`

## Requirements
- R1: The decoder tests the code in a fixed priority order, and the first match wins. low 3 bits 111 → control 0x07; low 2 bits 10 → read 0x02; low 4 bits 1100 → read-backward 0x0C; low 2 bits 01 → code & 0x83 when extended, else 0x01; low 5 bits 10100 → sense-command-byte 0x14; code & 0x47 == 0x03 → no-op 0x03; code & 0xC7 == 0x43 → set-basic 0x43. Any other code passes through unchanged. For example, 0x0B decodes as a no-op and 0x27 as control.
- R2: The device may be closed (dev_open low) while the raw code is neither sense class (low nibble 0100) nor control class (low two bits 11). In that case the command ends with status 0x0E and sense 0x40, and the residual equals the count. Status bits are CE = 0x08, DE = 0x04 and UC = 0x02.
- R3: A write (base 0x01) with a count of zero ends at once with status 0x0C and residual 0, and makes no data-path request.
- R4: Base 0x81 (write-end-of-file) exists only in extended mode. It ends with status 0x0C, the residual equals the count, and it moves no data. In basic mode the same code is an ordinary write.
- R5: Set-basic (base 0x43) in basic mode is rejected with status 0x0E and sense 0x80, and the mode is not changed. In extended mode it clears the mode, returns residual 0 and ends with status 0x0C.
- R6: Set-extended (0xC3) sets extended mode, returns residual 0 and ends with status 0x0C.
- R7: Control, no-op, prepare (0xE3) and sense-command-byte each end with status 0x0C. The residual equals the count, and none of them makes a data-path request.
- R8: Some commands go to the data path: read as operation 1, read-backward as operation 2, and a write with a nonzero count as operation 3, with dp_req_count set to the count. dp_req_valid and the request fields hold until dp_req_ready is seen, and cmd_ready stays low until the transfer completes.
- R9: When dp_done arrives while the block is waiting, the next edge copies dp_stat and dp_resid to unit_stat and residual and raises done for one cycle.
- R10: Sense-class commands leave the sense byte unchanged. Every other accepted command clears it, unless that command is rejected or meets the closed device. A plain sense command (0x04) ends with status 0x0C and residual equal to the count minus one, floored at zero.
- R11: Any code that R1 leaves unmatched, other than 0x04, 0xC3 and 0xE3, is rejected with status 0x0E and sense 0x80, and the residual equals the count.
- R12: After reset, xmode, sense, unit_stat, residual, done and dp_req_valid are 0 and cmd_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command presented |
| cmd_ready | output | 1 | Block can take a command |
| cmd_code | input | 8 | Raw command code |
| cmd_count | input | CNT_W | Byte count of the command |
| dev_open | input | 1 | Device behind the channel is open |
| done | output | 1 | One-cycle completion pulse |
| unit_stat | output | 8 | Unit status of the last command |
| sense | output | 8 | Sense byte (bit 7 reject, bit 6 intervention) |
| residual | output | CNT_W | Residual count of the last command |
| xmode | output | 1 | Extended mode flag |
| dp_req_valid | output | 1 | Data-path request valid |
| dp_req_ready | input | 1 | Data path takes the request |
| dp_req_op | output | 2 | 1 read, 2 read-backward, 3 write |
| dp_req_count | output | CNT_W | Byte count for the data path |
| dp_done | input | 1 | Data path finished |
| dp_stat | input | 8 | Status from the data path |
| dp_resid | input | CNT_W | Residual from the data path |

## Verification
The vector walk sends codes that sit on each priority boundary of the mask chain, such as 0x0B, 0x27, 0x43, 0xC3, 0xE3 and 0x24. A wrong test order or a wrong mask therefore changes the status or the sense byte. The same code 0x81 is applied in both modes to tell write-end-of-file apart from a zero-count write. Closed-device cases are applied with control-class, sense-class and write codes, which separates the exemption rule from the intervention response. Directed transfers use read, read-backward and a write whose ready is held off, which shows the request holding steady and the status being forwarded.

// File: rtl/chan_cmd_pkg.sv
package chan_cmd_pkg;

    localparam int CODE_W = 8;

    localparam logic [7:0] ST_CE = 8'h08;
    localparam logic [7:0] ST_DE = 8'h04;
    localparam logic [7:0] ST_UC = 8'h02;
    localparam logic [7:0] ST_OK  = ST_CE | ST_DE;
    localparam logic [7:0] ST_BAD = ST_CE | ST_DE | ST_UC;

    localparam logic [7:0] SNS_REJECT = 8'h80;
    localparam logic [7:0] SNS_INTREQ = 8'h40;

    localparam logic [7:0] OP_CTL   = 8'h07;
    localparam logic [7:0] OP_READ  = 8'h02;
    localparam logic [7:0] OP_RDBK  = 8'h0C;
    localparam logic [7:0] OP_WRITE = 8'h01;
    localparam logic [7:0] OP_WEOF  = 8'h81;
    localparam logic [7:0] OP_SCB   = 8'h14;
    localparam logic [7:0] OP_NOP   = 8'h03;
    localparam logic [7:0] OP_SBM   = 8'h43;
    localparam logic [7:0] OP_SEM   = 8'hC3;
    localparam logic [7:0] OP_PREP  = 8'hE3;
    localparam logic [7:0] OP_SENSE = 8'h04;

    typedef enum logic [1:0] {
        DP_NONE  = 2'd0,
        DP_READ  = 2'd1,
        DP_RDBK  = 2'd2,
        DP_WRITE = 2'd3
    } dp_op_e;

    typedef enum logic [3:0] {
        K_CTL, K_READ, K_RDBK, K_WRITE, K_WEOF, K_SCB, K_NOP,
        K_SBM, K_SEM, K_PREP, K_SENSE, K_INVALID
    } cmd_kind_e;

    typedef enum logic [1:0] {
        SNS_KEEP,
        SNS_CLEAR,
        SNS_LOAD
    } sense_act_e;

    typedef struct packed {
        logic [7:0] stat;
        sense_act_e sense_act;
        logic [7:0] sense_val;
        logic       mode_set;
        logic       mode_clr;
        dp_op_e     dp_op;
    } decision_t;

    // Ordered mask chain: the first matching test decides the base opcode.
    function automatic logic [7:0] reduce_code(input logic [7:0] c, input logic ext);
        logic [7:0] r;
        if ((c & 8'h07) == 8'h07)
            r = OP_CTL;
        else if ((c & 8'h03) == 8'h02)
            r = OP_READ;
        else if ((c & 8'h0F) == 8'h0C)
            r = OP_RDBK;
        else if ((c & 8'h03) == 8'h01)
            r = ext ? (c & 8'h83) : OP_WRITE;
        else if ((c & 8'h1F) == 8'h14)
            r = OP_SCB;
        else if ((c & 8'h47) == 8'h03)
            r = OP_NOP;
        else if ((c & 8'hC7) == 8'h43)
            r = OP_SBM;
        else
            r = c;
        return r;
    endfunction

    function automatic cmd_kind_e classify(input logic [7:0] base);
        cmd_kind_e k;
        case (base)
            OP_CTL:   k = K_CTL;
            OP_READ:  k = K_READ;
            OP_RDBK:  k = K_RDBK;
            OP_WRITE: k = K_WRITE;
            OP_WEOF:  k = K_WEOF;
            OP_SCB:   k = K_SCB;
            OP_NOP:   k = K_NOP;
            OP_SBM:   k = K_SBM;
            OP_SEM:   k = K_SEM;
            OP_PREP:  k = K_PREP;
            OP_SENSE: k = K_SENSE;
            default:  k = K_INVALID;
        endcase
        return k;
    endfunction

    function automatic logic is_sense_class(input logic [7:0] c);
        return c[3:0] == 4'h4;
    endfunction

    function automatic logic is_control_class(input logic [7:0] c);
        return c[1:0] == 2'b11;
    endfunction

endpackage

// File: rtl/ccc_decode.sv
module ccc_decode
    import chan_cmd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [7:0]       code,
    input  logic [CNT_W-1:0] count,
    input  logic             dev_open,
    input  logic             ext,
    output decision_t        dec,
    output logic [CNT_W-1:0] resid
);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic [7:0] base;
    cmd_kind_e  kind;
    logic       exempt;

    always_comb begin
        base   = reduce_code(code, ext);
        kind   = classify(base);
        exempt = is_sense_class(code) || is_control_class(code);
    end

    always_comb begin
        dec.stat      = ST_OK;
        dec.sense_act = SNS_CLEAR;
        dec.sense_val = 8'h00;
        dec.mode_set  = 1'b0;
        dec.mode_clr  = 1'b0;
        dec.dp_op     = DP_NONE;
        resid         = count;

        if (!dev_open && !exempt) begin
            dec.stat      = ST_BAD;
            dec.sense_act = SNS_LOAD;
            dec.sense_val = SNS_INTREQ;
        end else begin
            case (kind)
                K_READ:  dec.dp_op = DP_READ;
                K_RDBK:  dec.dp_op = DP_RDBK;
                K_WRITE: begin
                    if (count != ZERO)
                        dec.dp_op = DP_WRITE;
                end
                K_WEOF, K_CTL, K_NOP, K_PREP: begin
                    dec.stat = ST_OK;
                end
                K_SCB: begin
                    dec.sense_act = SNS_KEEP;
                end
                K_SENSE: begin
                    dec.sense_act = SNS_KEEP;
                    resid         = (count == ZERO) ? ZERO : count - ONE;
                end
                K_SEM: begin
                    dec.mode_set = 1'b1;
                    resid        = ZERO;
                end
                K_SBM: begin
                    if (ext) begin
                        dec.mode_clr = 1'b1;
                        resid        = ZERO;
                    end else begin
                        dec.stat      = ST_BAD;
                        dec.sense_act = SNS_LOAD;
                        dec.sense_val = SNS_REJECT;
                    end
                end
                default: begin
                    dec.stat      = ST_BAD;
                    dec.sense_act = SNS_LOAD;
                    dec.sense_val = SNS_REJECT;
                end
            endcase
        end
    end

endmodule

// File: rtl/ccc_mode_reg.sv
module ccc_mode_reg (
    input  logic clk,
    input  logic rst,
    input  logic set_ext,
    input  logic clr_ext,
    output logic ext
);
    always_ff @(posedge clk) begin
        if (rst)
            ext <= 1'b0;
        else if (set_ext)
            ext <= 1'b1;
        else if (clr_ext)
            ext <= 1'b0;
    end
endmodule

// File: rtl/ccc_xfer.sv
module ccc_xfer
    import chan_cmd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  dp_op_e           op,
    input  logic [CNT_W-1:0] count,
    output logic             busy,
    output logic             fin,
    output logic             dp_req_valid,
    input  logic             dp_req_ready,
    output logic [1:0]       dp_req_op,
    output logic [CNT_W-1:0] dp_req_count,
    input  logic             dp_done
);
    typedef enum logic [1:0] {
        XS_IDLE,
        XS_REQ,
        XS_WAIT
    } xstate_e;

    xstate_e          state;
    dp_op_e           op_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= XS_IDLE;
            op_q  <= DP_NONE;
            cnt_q <= '0;
        end else begin
            case (state)
                XS_IDLE: begin
                    if (start) begin
                        state <= XS_REQ;
                        op_q  <= op;
                        cnt_q <= count;
                    end
                end
                XS_REQ: begin
                    if (dp_req_ready)
                        state <= XS_WAIT;
                end
                XS_WAIT: begin
                    if (dp_done)
                        state <= XS_IDLE;
                end
                default: state <= XS_IDLE;
            endcase
        end
    end

    always_comb begin
        busy         = (state != XS_IDLE);
        fin          = (state == XS_WAIT) && dp_done;
        dp_req_valid = (state == XS_REQ);
        dp_req_op    = op_q;
        dp_req_count = cnt_q;
    end

endmodule

// File: rtl/chan_cmd_exec.sv
module chan_cmd_exec
    import chan_cmd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [7:0]       cmd_code,
    input  logic [CNT_W-1:0] cmd_count,
    input  logic             dev_open,
    output logic             done,
    output logic [7:0]       unit_stat,
    output logic [7:0]       sense,
    output logic [CNT_W-1:0] residual,
    output logic             xmode,
    output logic             dp_req_valid,
    input  logic             dp_req_ready,
    output logic [1:0]       dp_req_op,
    output logic [CNT_W-1:0] dp_req_count,
    input  logic             dp_done,
    input  logic [7:0]       dp_stat,
    input  logic [CNT_W-1:0] dp_resid
);
    decision_t        dec;
    logic [CNT_W-1:0] dec_resid;
    logic             accept;
    logic             busy;
    logic             fin;
    logic             to_path;

    ccc_decode #(.CNT_W(CNT_W)) u_dec (
        .code     (cmd_code),
        .count    (cmd_count),
        .dev_open (dev_open),
        .ext      (xmode),
        .dec      (dec),
        .resid    (dec_resid)
    );

    always_comb begin
        cmd_ready = !busy;
        accept    = cmd_valid && cmd_ready;
        to_path   = (dec.dp_op != DP_NONE);
    end

    ccc_mode_reg u_mode (
        .clk     (clk),
        .rst     (rst),
        .set_ext (accept && dec.mode_set),
        .clr_ext (accept && dec.mode_clr),
        .ext     (xmode)
    );

    ccc_xfer #(.CNT_W(CNT_W)) u_xfer (
        .clk          (clk),
        .rst          (rst),
        .start        (accept && to_path),
        .op           (dec.dp_op),
        .count        (cmd_count),
        .busy         (busy),
        .fin          (fin),
        .dp_req_valid (dp_req_valid),
        .dp_req_ready (dp_req_ready),
        .dp_req_op    (dp_req_op),
        .dp_req_count (dp_req_count),
        .dp_done      (dp_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done      <= 1'b0;
            unit_stat <= 8'h00;
            residual  <= '0;
            sense     <= 8'h00;
        end else begin
            done <= 1'b0;
            if (accept) begin
                case (dec.sense_act)
                    SNS_CLEAR: sense <= 8'h00;
                    SNS_LOAD:  sense <= dec.sense_val;
                    default:   sense <= sense;
                endcase
                if (!to_path) begin
                    unit_stat <= dec.stat;
                    residual  <= dec_resid;
                    done      <= 1'b1;
                end
            end else if (fin) begin
                unit_stat <= dp_stat;
                residual  <= dp_resid;
                done      <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/chan_cmd_exec_chk.sv
module chan_cmd_exec_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [7:0]       cmd_code,
    input logic [CNT_W-1:0] cmd_count,
    input logic             dev_open,
    input logic             done,
    input logic [7:0]       unit_stat,
    input logic [7:0]       sense,
    input logic [CNT_W-1:0] residual,
    input logic             xmode,
    input logic             dp_req_valid,
    input logic             dp_req_ready,
    input logic [CNT_W-1:0] dp_req_count,
    input logic             dp_done
);
    logic acc;
    always_comb acc = cmd_valid && cmd_ready;

    a_r2_closed_device: assert property (@(posedge clk) disable iff (rst)
        acc && !dev_open && cmd_code[1:0] != 2'b11 && cmd_code[3:0] != 4'h4
        |=> done && unit_stat == 8'h0E && sense == 8'h40);

    a_r3_zero_write: assert property (@(posedge clk) disable iff (rst)
        acc && dev_open && cmd_code == 8'h01 && cmd_count == '0
        |=> done && unit_stat == 8'h0C && !dp_req_valid);

    a_r5_basic_reject: assert property (@(posedge clk) disable iff (rst)
        acc && dev_open && cmd_code == 8'h43 && !xmode
        |=> !xmode && sense == 8'h80 && unit_stat == 8'h0E);

    a_r6_set_ext: assert property (@(posedge clk) disable iff (rst)
        acc && dev_open && cmd_code == 8'hC3
        |=> xmode && residual == '0 && unit_stat == 8'h0C);

    a_r8_req_hold: assert property (@(posedge clk) disable iff (rst)
        dp_req_valid && !dp_req_ready |=> dp_req_valid && $stable(dp_req_count));

    a_r8_busy_block: assert property (@(posedge clk) disable iff (rst)
        dp_req_valid |-> !cmd_ready);

    a_r9_done_cause: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(acc) || $past(dp_done));

    a_r6_mode_quiet: assert property (@(posedge clk) disable iff (rst)
        !acc |=> $stable(xmode));

endmodule

bind chan_cmd_exec chan_cmd_exec_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_code     (cmd_code),
    .cmd_count    (cmd_count),
    .dev_open     (dev_open),
    .done         (done),
    .unit_stat    (unit_stat),
    .sense        (sense),
    .residual     (residual),
    .xmode        (xmode),
    .dp_req_valid (dp_req_valid),
    .dp_req_ready (dp_req_ready),
    .dp_req_count (dp_req_count),
    .dp_done      (dp_done)
);

// File: tb/chan_cmd_exec_tb.sv
`timescale 1ns/1ps
module chan_cmd_exec_tb;
    localparam int CNT_W = 16;
    localparam int NV = 21;

    logic             clk = 1'b0;
    logic             rst;
    logic             cmd_valid;
    logic             cmd_ready;
    logic [7:0]       cmd_code;
    logic [CNT_W-1:0] cmd_count;
    logic             dev_open;
    logic             done;
    logic [7:0]       unit_stat;
    logic [7:0]       sense;
    logic [CNT_W-1:0] residual;
    logic             xmode;
    logic             dp_req_valid;
    logic             dp_req_ready;
    logic [1:0]       dp_req_op;
    logic [CNT_W-1:0] dp_req_count;
    logic             dp_done;
    logic [7:0]       dp_stat;
    logic [CNT_W-1:0] dp_resid;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    chan_cmd_exec #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_code(cmd_code), .cmd_count(cmd_count), .dev_open(dev_open),
        .done(done), .unit_stat(unit_stat), .sense(sense), .residual(residual),
        .xmode(xmode), .dp_req_valid(dp_req_valid), .dp_req_ready(dp_req_ready),
        .dp_req_op(dp_req_op), .dp_req_count(dp_req_count), .dp_done(dp_done),
        .dp_stat(dp_stat), .dp_resid(dp_resid)
    );

    // {code, count, open, exp_stat, exp_sense, exp_resid, exp_mode, req}
    localparam logic [61:0] VEC [NV] = '{
        {8'h43, 16'd5,  1'b1, 8'h0E, 8'h80, 16'd5,  1'b0, 4'd5},  // R5 basic reject
        {8'h14, 16'd7,  1'b1, 8'h0C, 8'h80, 16'd7,  1'b0, 4'd10}, // R10 scb keeps sense
        {8'h04, 16'd3,  1'b1, 8'h0C, 8'h80, 16'd2,  1'b0, 4'd10}, // R10 sense count-1
        {8'h07, 16'd9,  1'b1, 8'h0C, 8'h00, 16'd9,  1'b0, 4'd7},  // R7 control
        {8'hC3, 16'd4,  1'b1, 8'h0C, 8'h00, 16'd0,  1'b1, 4'd6},  // R6 set extended
        {8'h81, 16'd6,  1'b1, 8'h0C, 8'h00, 16'd6,  1'b1, 4'd4},  // R4 weof extended
        {8'h01, 16'd0,  1'b1, 8'h0C, 8'h00, 16'd0,  1'b1, 4'd3},  // R3 zero write
        {8'hE3, 16'd2,  1'b1, 8'h0C, 8'h00, 16'd2,  1'b1, 4'd7},  // R7 prepare
        {8'h03, 16'd11, 1'b1, 8'h0C, 8'h00, 16'd11, 1'b1, 4'd7},  // R7 nop
        {8'h08, 16'd5,  1'b1, 8'h0E, 8'h80, 16'd5,  1'b1, 4'd11}, // R11 invalid
        {8'h0B, 16'd1,  1'b1, 8'h0C, 8'h00, 16'd1,  1'b1, 4'd1},  // R1 nop by mask
        {8'h02, 16'd8,  1'b0, 8'h0E, 8'h40, 16'd8,  1'b1, 4'd2},  // R2 closed read
        {8'hC3, 16'd3,  1'b0, 8'h0C, 8'h00, 16'd0,  1'b1, 4'd2},  // R2 control exempt
        {8'h04, 16'd0,  1'b0, 8'h0C, 8'h00, 16'd0,  1'b1, 4'd2},  // R2 sense exempt
        {8'h43, 16'd10, 1'b1, 8'h0C, 8'h00, 16'd0,  1'b0, 4'd5},  // R5 back to basic
        {8'h81, 16'd0,  1'b1, 8'h0C, 8'h00, 16'd0,  1'b0, 4'd4},  // R4 basic: plain write
        {8'h81, 16'd0,  1'b0, 8'h0E, 8'h40, 16'd0,  1'b0, 4'd2},  // R2 closed write
        {8'h27, 16'd3,  1'b1, 8'h0C, 8'h00, 16'd3,  1'b0, 4'd1},  // R1 control by mask
        {8'h00, 16'd2,  1'b1, 8'h0E, 8'h80, 16'd2,  1'b0, 4'd11}, // R11 zero code
        {8'h24, 16'd4,  1'b1, 8'h0E, 8'h80, 16'd4,  1'b0, 4'd1},  // R1 pass-through rejected
        {8'h05, 16'd0,  1'b1, 8'h0C, 8'h00, 16'd0,  1'b0, 4'd3}   // R3 basic 0x05 write
    };

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic issue(input logic [7:0] c, input logic [15:0] n, input logic op);
        @(negedge clk);
        cmd_code  = c;
        cmd_count = n;
        dev_open  = op;
        cmd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic check_reset_state();
        check(xmode == 0 && sense == 0 && unit_stat == 0 && residual == 0,
              "R12", "regs", {xmode, sense, unit_stat, residual}, 0);
        check(done == 0 && dp_req_valid == 0 && cmd_ready == 1,
              "R12", "handshake", {done, dp_req_valid, cmd_ready}, 3'b001);
    endtask

    task automatic transfer(input logic [7:0] c, input logic [15:0] n,
                            input logic [1:0] exp_op, input int stall,
                            input logic [7:0] ps, input logic [15:0] pr);
        issue(c, n, 1'b1);
        check(dp_req_valid == 1 && dp_req_op == exp_op && dp_req_count == n,
              "R8", "request", {dp_req_valid, dp_req_op, dp_req_count},
              {1'b1, exp_op, n});
        check(cmd_ready == 0 && done == 0, "R8", "busy", {cmd_ready, done}, 0);
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            check(dp_req_valid == 1 && dp_req_count == n, "R8", "hold",
                  {dp_req_valid, dp_req_count}, {1'b1, n});
        end
        dp_req_ready = 1'b1;
        @(negedge clk);
        dp_req_ready = 1'b0;
        check(dp_req_valid == 0 && cmd_ready == 0, "R8", "accepted",
              {dp_req_valid, cmd_ready}, 0);
        dp_done  = 1'b1;
        dp_stat  = ps;
        dp_resid = pr;
        @(negedge clk);
        dp_done = 1'b0;
        check(done == 1 && unit_stat == ps && residual == pr && sense == 0,
              "R9", "completion", {done, unit_stat, residual, sense},
              {1'b1, ps, pr, 8'h00});
        @(negedge clk);
        check(done == 0 && cmd_ready == 1, "R9", "pulse end", {done, cmd_ready}, 2'b01);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst = 1'b1; cmd_valid = 0; cmd_code = 0; cmd_count = 0; dev_open = 1;
        dp_req_ready = 0; dp_done = 0; dp_stat = 0; dp_resid = 0;
        do_reset();
        check_reset_state();

        for (int v = 0; v < NV; v++) begin
            logic [61:0] e;
            e = VEC[v];
            issue(e[61:54], e[53:38], e[37]);
            check(done == 1 && unit_stat == e[36:29] && sense == e[28:21] &&
                  residual == e[20:5] && xmode == e[4] && dp_req_valid == 0,
                  $sformatf("R%0d", e[3:0]), $sformatf("vector %0d", v),
                  {done, unit_stat, sense, residual, xmode},
                  {1'b1, e[36:29], e[28:21], e[20:5], e[4]});
        end

        // R8/R9: read, read-backward, stalled write
        issue(8'h43, 16'd1, 1'b1);          // leaves sense at reject before transfer
        transfer(8'h0E, 16'd40, 2'd1, 0, 8'h0C, 16'd0);
        transfer(8'h1C, 16'd12, 2'd2, 0, 8'h0D, 16'd5);
        transfer(8'h01, 16'h20, 2'd3, 3, 8'h0C, 16'd0);
        // R4 in extended mode: 0x05 decodes to a write, 0x85 to write-end-of-file
        issue(8'hC3, 16'd0, 1'b1);
        transfer(8'h05, 16'd6, 2'd3, 1, 8'h0C, 16'd1);
        issue(8'h85, 16'd9, 1'b1);
        check(done == 1 && unit_stat == 8'h0C && residual == 16'd9 && dp_req_valid == 0,
              "R4", "weof 0x85", {done, unit_stat, residual}, {1'b1, 8'h0C, 16'd9});

        // R12: reset from a dirty state
        issue(8'h08, 16'd3, 1'b1);
        do_reset();
        check_reset_state();
        finish_run();
    end
endmodule